// File: doc/BRIEF.md
# DS3 Transmit Frame Reference Generator

This block supplies free-running DS3 frame timing to a bit-serial terminal-side source. It runs on a 44.736 MHz reference clock and passes that clock out unchanged as the output bit clock. Against that clock it walks a 4760-bit frame: 7 subframes, each of 8 groups of 85 bits. The frame is tracked by three cascaded wrap counters.

On every bit the block drives three registered outputs. An active-low frame strobe marks bit 1 of the frame. An active-low gap strobe marks the single overhead bit that opens each 85-bit group, which gives 56 per frame. A reference data line carries the framing pattern and nothing else. The framing pattern is the four F bits in every subframe and the three M bits in the last three subframes. Every other position, including the remaining overhead slots, is driven low. A source aligns its payload to the strobes and fills the low positions.

Reset is asynchronous and active low. Its release passes through a two-stage synchronizer before the counters start.

Top module: `ds3ref_gen`

## Requirements
- R1: `clk_out_o` follows `clk_ref_i`: it is low while the reference clock is low and high while the reference clock is high.
- R2: While `rst_ref_n_i` is low, the outputs are idle: `frame_n_o` = 1, `gap_n_o` = 1, `data_o` = 0. This holds at once when reset is asserted mid-frame, with no clock edge needed.
- R3: After `rst_ref_n_i` rises, the outputs present frame bit 1 from the third rising clock edge onward. Bit 1 shows `frame_n_o` = 0, `gap_n_o` = 0 and `data_o` = 0.
- R4: `frame_n_o` is low for exactly one clock in every 4760 clocks, always on frame bit 1.
- R5: `gap_n_o` is low for exactly one clock in every 85 clocks, on the first bit of each group, which gives 56 lows per frame.
- R6: Groups are numbered 1 to 8 within a subframe. On the first bit of groups 2, 4, 6 and 8, `data_o` is 1, 0, 0, 1 in that order, in every subframe.
- R7: On the first bit of group 1 of subframes 5, 6 and 7, `data_o` is 0, 1, 0 respectively.
- R8: `data_o` is 0 on the first bit of group 1 in subframes 1 to 4. It is also 0 on the first bit of groups 3, 5 and 7 in every subframe.
- R9: On every bit that is not the first bit of a group, `data_o` is 0 and both strobes are high.
- R10: A reset asserted mid-frame restarts the sequence at frame bit 1 once it is released, with the same latency as R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref_i | input | 1 | 44.736 MHz reference clock |
| rst_ref_n_i | input | 1 | Asynchronous active-low reset |
| clk_out_o | output | 1 | Output bit clock derived from the reference clock |
| frame_n_o | output | 1 | Active-low strobe on frame bit 1 |
| gap_n_o | output | 1 | Active-low strobe on the overhead bit of each 85-bit group |
| data_o | output | 1 | Reference data carrying only the M and F bits, low elsewhere |

## Verification
Each counter shows its own fault at the ports within a known time:
- A bit counter that slips or wraps at the wrong value moves the gap strobe off its 85-clock spacing. This shows within one group.
- A group or subframe counter fault leaves the gap strobe intact but places the wrong F or M value on `data_o`. It also moves the frame strobe off its 4760-clock period, so it shows at the next overhead bit or, at the latest, within one frame.
- A decode fault that puts framing values on payload bits, or loses the low state of the remaining overhead slots, shows on the first affected bit.

For these reasons every bit of a full frame is compared against an independent position model. The restart position after reset is checked at the exact clock the release latency predicts.

// File: rtl/ds3ref_pkg.sv
`timescale 1ns/1ps
package ds3ref_pkg;

  // Default DS3 frame geometry
  localparam int unsigned DEF_GROUP_BITS = 85;
  localparam int unsigned DEF_GROUPS     = 8;
  localparam int unsigned DEF_SUBFRAMES  = 7;
  localparam int unsigned DEF_M_SUBS     = 3;

  // One bit position's worth of reference outputs
  typedef struct packed {
    logic frame_n;
    logic gap_n;
    logic data;
  } ref_slot_t;

  localparam ref_slot_t SLOT_IDLE = '{frame_n: 1'b1, gap_n: 1'b1, data: 1'b0};

endpackage

// File: rtl/ds3ref_rst_sync.sv
`timescale 1ns/1ps
module ds3ref_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic run_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign run_o = sync_q[STAGES-1];

endmodule

// File: rtl/ds3ref_wrap_ctr.sv
`timescale 1ns/1ps
module ds3ref_wrap_ctr #(
  parameter int unsigned MOD = 85,
  localparam int unsigned W  = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk_i,
  input  logic         arst_n_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = en_i & at_last;

endmodule

// File: rtl/ds3ref_slot_decode.sv
`timescale 1ns/1ps
module ds3ref_slot_decode
  import ds3ref_pkg::*;
#(
  parameter int unsigned GROUP_BITS = DEF_GROUP_BITS,
  parameter int unsigned GROUPS     = DEF_GROUPS,
  parameter int unsigned SUBFRAMES  = DEF_SUBFRAMES,
  parameter int unsigned M_SUBS     = DEF_M_SUBS,
  parameter logic [GROUPS/2-1:0] F_SEQ = 4'b1001,
  parameter logic [M_SUBS-1:0]   M_SEQ = 3'b010,
  localparam int unsigned BIT_W = $clog2(GROUP_BITS),
  localparam int unsigned GRP_W = $clog2(GROUPS),
  localparam int unsigned SUB_W = $clog2(SUBFRAMES)
) (
  input  logic [BIT_W-1:0] bit_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic [SUB_W-1:0] sub_i,
  output ref_slot_t        slot_o
);

  localparam int NF      = GROUPS / 2;
  localparam int M_FIRST = SUBFRAMES - M_SUBS;

  // F value for an odd group: first F in the subframe sits at the MSB of F_SEQ
  function automatic logic pick_f(input logic [GRP_W-1:0] g);
    int   k;
    logic r;
    k = NF - 1 - int'(g >> 1);
    r = 1'b0;
    for (int i = 0; i < NF; i++) begin
      if (i == k) r = F_SEQ[i];
    end
    return r;
  endfunction

  // M value for a subframe in the M zone: first M at the MSB of M_SEQ
  function automatic logic pick_m(input logic [SUB_W-1:0] s);
    int   k;
    logic r;
    k = int'(M_SUBS) - 1 - (int'(s) - M_FIRST);
    r = 1'b0;
    for (int i = 0; i < int'(M_SUBS); i++) begin
      if (i == k) r = M_SEQ[i];
    end
    return r;
  endfunction

  logic is_ovh;
  logic first_grp;
  logic m_zone;

  assign is_ovh    = (bit_i == '0);
  assign first_grp = (grp_i == '0);
  assign m_zone    = (int'(sub_i) >= M_FIRST);

  always_comb begin
    slot_o = SLOT_IDLE;
    if (is_ovh) begin
      slot_o.gap_n = 1'b0;
      if (first_grp && (sub_i == '0)) begin
        slot_o.frame_n = 1'b0;
      end
      if (grp_i[0]) begin
        slot_o.data = pick_f(grp_i);
      end else if (first_grp && m_zone) begin
        slot_o.data = pick_m(sub_i);
      end
    end
  end

endmodule

// File: rtl/ds3ref_gen.sv
`timescale 1ns/1ps
module ds3ref_gen
  import ds3ref_pkg::*;
#(
  parameter int unsigned GROUP_BITS  = DEF_GROUP_BITS,
  parameter int unsigned GROUPS      = DEF_GROUPS,
  parameter int unsigned SUBFRAMES   = DEF_SUBFRAMES,
  parameter int unsigned M_SUBS      = DEF_M_SUBS,
  parameter logic [GROUPS/2-1:0] F_SEQ = 4'b1001,
  parameter logic [M_SUBS-1:0]   M_SEQ = 3'b010,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_ref_i,
  input  logic rst_ref_n_i,
  output logic clk_out_o,
  output logic frame_n_o,
  output logic gap_n_o,
  output logic data_o
);

  localparam int unsigned BIT_W = $clog2(GROUP_BITS);
  localparam int unsigned GRP_W = $clog2(GROUPS);
  localparam int unsigned SUB_W = $clog2(SUBFRAMES);

  logic             run;
  logic [BIT_W-1:0] bit_cnt;
  logic [GRP_W-1:0] grp_cnt;
  logic [SUB_W-1:0] sub_cnt;
  logic             bit_wrap;
  logic             grp_wrap;
  logic             sub_wrap;
  ref_slot_t        slot_d;
  ref_slot_t        slot_q;

  // Output bit clock is the reference clock itself
  assign clk_out_o = clk_ref_i;

  ds3ref_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_ref_i),
    .arst_n_i (rst_ref_n_i),
    .run_o    (run)
  );

  // Bit within group, group within subframe, subframe within frame
  ds3ref_wrap_ctr #(.MOD(GROUP_BITS)) u_bit_ctr (
    .clk_i    (clk_ref_i),
    .arst_n_i (rst_ref_n_i),
    .en_i     (run),
    .cnt_o    (bit_cnt),
    .wrap_o   (bit_wrap)
  );

  ds3ref_wrap_ctr #(.MOD(GROUPS)) u_grp_ctr (
    .clk_i    (clk_ref_i),
    .arst_n_i (rst_ref_n_i),
    .en_i     (bit_wrap),
    .cnt_o    (grp_cnt),
    .wrap_o   (grp_wrap)
  );

  ds3ref_wrap_ctr #(.MOD(SUBFRAMES)) u_sub_ctr (
    .clk_i    (clk_ref_i),
    .arst_n_i (rst_ref_n_i),
    .en_i     (grp_wrap),
    .cnt_o    (sub_cnt),
    .wrap_o   (sub_wrap)
  );

  ds3ref_slot_decode #(
    .GROUP_BITS (GROUP_BITS),
    .GROUPS     (GROUPS),
    .SUBFRAMES  (SUBFRAMES),
    .M_SUBS     (M_SUBS),
    .F_SEQ      (F_SEQ),
    .M_SEQ      (M_SEQ)
  ) u_decode (
    .bit_i  (bit_cnt),
    .grp_i  (grp_cnt),
    .sub_i  (sub_cnt),
    .slot_o (slot_d)
  );

  // Registered outputs, clock-enabled by the released reset
  always_ff @(posedge clk_ref_i or negedge rst_ref_n_i) begin
    if (!rst_ref_n_i) begin
      slot_q <= SLOT_IDLE;
    end else if (run) begin
      slot_q <= slot_d;
    end
  end

  assign frame_n_o = slot_q.frame_n;
  assign gap_n_o   = slot_q.gap_n;
  assign data_o    = slot_q.data;

  logic unused_wrap;
  assign unused_wrap = sub_wrap;

endmodule

// File: rtl/ds3ref_gen_chk.sv
`timescale 1ns/1ps
module ds3ref_gen_chk #(
  parameter int unsigned GROUP_BITS = 85,
  parameter int unsigned GROUPS     = 8,
  parameter int unsigned SUBFRAMES  = 7
) (
  input logic clk_ref_i,
  input logic rst_ref_n_i,
  input logic frame_n_o,
  input logic gap_n_o,
  input logic data_o
);

  localparam int unsigned FRAME_BITS = GROUP_BITS * GROUPS * SUBFRAMES;
  localparam int unsigned FW = $clog2(FRAME_BITS);
  localparam int unsigned GW = $clog2(GROUP_BITS);

  logic [FW-1:0] fcnt_q;
  logic          fseen_q;
  logic [GW-1:0] gcnt_q;
  logic          gseen_q;

  always_ff @(posedge clk_ref_i or negedge rst_ref_n_i) begin
    if (!rst_ref_n_i) begin
      fcnt_q  <= '0;
      fseen_q <= 1'b0;
      gcnt_q  <= '0;
      gseen_q <= 1'b0;
    end else begin
      if (!frame_n_o) begin
        fcnt_q  <= '0;
        fseen_q <= 1'b1;
      end else if (fseen_q) begin
        fcnt_q <= fcnt_q + 1'b1;
      end
      if (!gap_n_o) begin
        gcnt_q  <= '0;
        gseen_q <= 1'b1;
      end else if (gseen_q) begin
        gcnt_q <= gcnt_q + 1'b1;
      end
    end
  end

  // R4: frame strobe recurs exactly every frame length
  assert_frame_period_R4: assert property (@(posedge clk_ref_i) disable iff (!rst_ref_n_i)
    fseen_q |-> ((fcnt_q == FW'(FRAME_BITS - 1)) == !frame_n_o));

  // R5: gap strobe recurs exactly every group length
  assert_gap_period_R5: assert property (@(posedge clk_ref_i) disable iff (!rst_ref_n_i)
    gseen_q |-> ((gcnt_q == GW'(GROUP_BITS - 1)) == !gap_n_o));

  // R5: frame bit 1 is also a group overhead bit
  assert_frame_in_gap_R5: assert property (@(posedge clk_ref_i) disable iff (!rst_ref_n_i)
    !frame_n_o |-> !gap_n_o);

  // R9: reference data is high only on overhead bits
  assert_data_on_ovh_R9: assert property (@(posedge clk_ref_i) disable iff (!rst_ref_n_i)
    data_o |-> !gap_n_o);

  // R8: the first overhead slot of the frame is low
  assert_first_slot_low_R8: assert property (@(posedge clk_ref_i) disable iff (!rst_ref_n_i)
    !frame_n_o |-> !data_o);

  // R4: the frame strobe lasts one clock
  assert_frame_single_R4: assert property (@(posedge clk_ref_i) disable iff (!rst_ref_n_i)
    !frame_n_o |=> frame_n_o);

endmodule

bind ds3ref_gen ds3ref_gen_chk #(
  .GROUP_BITS (GROUP_BITS),
  .GROUPS     (GROUPS),
  .SUBFRAMES  (SUBFRAMES)
) u_chk (
  .clk_ref_i   (clk_ref_i),
  .rst_ref_n_i (rst_ref_n_i),
  .frame_n_o   (frame_n_o),
  .gap_n_o     (gap_n_o),
  .data_o      (data_o)
);

// File: tb/ds3ref_gen_test.sv
`timescale 1ns/1ps
module ds3ref_gen_test;

  localparam int GB = 85;
  localparam int NG = 8;
  localparam int FRAME = 4760;

  logic clk;
  logic rst_n;
  logic clk_out;
  logic frame_n;
  logic gap_n;
  logic data;

  int checks;
  int errors;
  bit done;

  ds3ref_gen uut (
    .clk_ref_i   (clk),
    .rst_ref_n_i (rst_n),
    .clk_out_o   (clk_out),
    .frame_n_o   (frame_n),
    .gap_n_o     (gap_n),
    .data_o      (data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected outputs at frame position p (0 = frame bit 1)
  task automatic model(input int p, output int f, output int g, output int d);
    int b, gr, sb;
    b  = p % GB;
    gr = (p / GB) % NG;
    sb = p / (GB * NG);
    f = (p == 0) ? 0 : 1;
    g = (b == 0) ? 0 : 1;
    d = 0;
    if (b == 0) begin
      if (gr == 1 || gr == 7) d = 1;
      else if (gr == 0 && sb == 5) d = 1;
    end
  endtask

  // Release reset at a falling edge and wait until bit 1 is visible
  task automatic release_and_align();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R2", "frame_n in reset", int'(frame_n), 1);
    check("R2", "gap_n in reset", int'(gap_n), 1);
    check("R2", "data in reset", int'(data), 0);
  endtask

  task automatic t_clock_out();
    @(negedge clk);
    #1 check("R1", "clk_out low phase", int'(clk_out), 0);
    @(posedge clk);
    #1 check("R1", "clk_out high phase", int'(clk_out), 1);
  endtask

  task automatic t_startup();
    // Two edges before bit 1: outputs must still be idle
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R3", "frame_n before start", int'(frame_n), 1);
    @(posedge clk);
    @(negedge clk);
    check("R3", "frame_n at start", int'(frame_n), 0);
    check("R3", "gap_n at start", int'(gap_n), 0);
    check("R3", "data at start", int'(data), 0);
  endtask

  // Walk one full frame starting at a sample of bit 1
  task automatic t_frame_walk();
    int f, g, d, bad_pay, frames, gaps;
    bad_pay = 0; frames = 0; gaps = 0;
    for (int p = 0; p < FRAME; p++) begin
      model(p, f, g, d);
      if (!frame_n) frames++;
      if (!gap_n) gaps++;
      if (p % GB == 0) begin
        int gr, sb;
        gr = (p / GB) % NG;
        sb = p / (GB * NG);
        check("R5", $sformatf("gap_n at pos %0d", p), int'(gap_n), g);
        if (gr % 2 == 1)
          check("R6", $sformatf("F bit at pos %0d", p), int'(data), d);
        else if (gr == 0 && sb >= 4)
          check("R7", $sformatf("M bit at pos %0d", p), int'(data), d);
        else
          check("R8", $sformatf("low slot at pos %0d", p), int'(data), d);
      end else begin
        if (data || !gap_n || !frame_n) bad_pay++;
      end
      @(negedge clk);
    end
    check("R9", "payload bits not low", bad_pay, 0);
    check("R4", "frame strobes per frame", frames, 1);
    check("R5", "gap strobes per frame", gaps, 56);
  endtask

  task automatic t_second_frame();
    int extra;
    check("R4", "frame_n at second frame start", int'(frame_n), 0);
    extra = 0;
    for (int p = 1; p < FRAME; p++) begin
      @(negedge clk);
      if (!frame_n) extra++;
    end
    check("R4", "extra frame strobes in second frame", extra, 0);
    @(negedge clk);
    check("R4", "frame_n at third frame start", int'(frame_n), 0);
  endtask

  task automatic t_midreset();
    repeat (1000) @(negedge clk);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 check("R2", "frame_n after async reset", int'(frame_n), 1);
    check("R2", "gap_n after async reset", int'(gap_n), 1);
    release_and_align();
    check("R10", "frame_n after restart", int'(frame_n), 0);
    @(negedge clk);
    check("R10", "frame_n one bit later", int'(frame_n), 1);
    repeat (GB - 1) @(negedge clk);
    check("R10", "gap_n at second group", int'(gap_n), 0);
    check("R10", "F1 at second group", int'(data), 1);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    t_reset_state();
    t_clock_out();
    t_startup();
    t_frame_walk();
    t_second_frame();
    t_midreset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule